// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block selects the operating mode of a small microcontroller core: reset, run, idle, power-down, the wake-up phase that follows power-down, and an on-circuit emulation mode in which the chip stays off the board's buses so that an external test processor can take over. It watches the external reset pin, the address-latch and program-strobe pin levels during reset, software requests for idle and power-down, a flag for pending enabled interrupts, and the external interrupt pins together with their enable and trigger settings.

From the mode it produces the core reset, clock enables for the CPU, the oscillator, the peripherals and the counter array, and drive controls for the address-latch pin, the program-strobe pin and port 0. Every pin input passes through a two-stage synchroniser. A reset pulse counts only after it has been seen for two full machine cycles. Leaving power-down through an interrupt is done in two phases. A low level on a qualifying pin restarts the oscillator. The exit completes only once a programmable settling count has elapsed and the pin has returned high.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The reset pin must be seen high (after synchronisation) for MC_CYCLES*RST_MC consecutive clock cycles before core_rst_o rises and mode_o becomes RESET (code 0). A shorter pulse changes neither output.
- R2: Once the synchronised reset pin is low again, reset ends. core_rst_o falls and mode_o becomes RUN (code 1), unless R3 applies.
- R3: If the address-latch pin is seen low while the program-strobe pin is high at any time during reset, and the address-latch pin is still low when reset ends, the mode becomes EMU (code 5). In EMU: p0_ctl_o is FLOAT (2), ale_ctl_o and psen_ctl_o are WEAK (3), port_weak_o is 1, osc_en_o is 1 and cpu_clk_en_o is 0. If either condition is missing, the mode becomes RUN.
- R4: EMU is left only through a qualified reset. Idle requests, power-down requests and pending interrupts leave mode_o at 5.
- R5: A one-cycle idle_req_i in RUN gives mode IDLE (code 2) at the next edge. In IDLE: cpu_clk_en_o is 0, per_clk_en_o and osc_en_o are 1, ale_ctl_o and psen_ctl_o are HIGH (1), and cnt_clk_en_o follows cnt_idle_run_i.
- R6: In IDLE, irq_pend_i high returns the mode to RUN at the next edge, with cpu_clk_en_o set to 1.
- R7: A pd_req_i in RUN gives mode PD (code 3) at the next edge, and takes priority over a simultaneous idle_req_i. In PD: osc_en_o, cpu_clk_en_o and per_clk_en_o are 0, and ale_ctl_o and psen_ctl_o are LOW (2).
- R8: p0_ctl_o is FUNC (0) in RUN. In IDLE and PD it is FLOAT (2) when ext_exec_i is 1 and HOLD (1) when ext_exec_i is 0.
- R9: In PD, only an interrupt pin whose enable bit is 1 and whose trigger bit is 0 (level) wakes the block when held low. A low level on a disabled pin or on an edge-triggered pin (trigger bit 1) leaves osc_en_o at 0 and the mode at PD.
- R10: A qualifying low level in PD moves the mode to WAKE (code 4), with osc_en_o 1 and cpu_clk_en_o 0. The mode returns to RUN only after stab_cnt_i cycles have been counted in WAKE and no qualifying pin is low any more.
- R11: A qualified reset in IDLE or PD moves the mode to RESET. After release the mode is RUN, with no emulation state carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| rst_pin_i | input | 1 | External reset pin level, active high |
| ale_pin_i | input | 1 | Address-latch pin level sampled during reset |
| psen_pin_i | input | 1 | Program-strobe pin level sampled during reset |
| idle_req_i | input | 1 | Software request for idle, one cycle |
| pd_req_i | input | 1 | Software request for power-down, one cycle |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| ext_int_n_i | input | NUM_INT | External interrupt pins, active low |
| ext_int_en_i | input | NUM_INT | Per-pin interrupt enable |
| ext_int_edge_i | input | NUM_INT | Per-pin trigger: 1 edge, 0 level |
| ext_exec_i | input | 1 | Program runs from external memory |
| cnt_idle_run_i | input | 1 | Keep the counter array clocked in idle |
| stab_cnt_i | input | STAB_W | Oscillator settling count for power-down exit |
| core_rst_o | output | 1 | Core reset |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| cnt_clk_en_o | output | 1 | Counter-array clock enable |
| ale_ctl_o | output | 2 | Address-latch pin drive: 0 FUNC, 1 HIGH, 2 LOW, 3 WEAK |
| psen_ctl_o | output | 2 | Program-strobe pin drive, same coding |
| p0_ctl_o | output | 2 | Port 0 drive: 0 FUNC, 1 HOLD, 2 FLOAT |
| port_weak_o | output | 1 | Other ports weakly pulled high |
| mode_o | output | 3 | Mode: 0 RESET, 1 RUN, 2 IDLE, 3 PD, 4 WAKE, 5 EMU |

## Verification
The bench drives a reset pulse one cycle short of qualification. A filter that counted from the raw pin, or one that was off by one, would reset the core on that glitch. It also covers the case where the address-latch pin goes low during reset but returns high before release. A design that latched the emulation decision early would stay off the bus in that case. For power-down wake-up, the bench releases the interrupt pin before the settling count ends and checks that the CPU clock stays off. It also holds the pin low well past the count and checks that the exit waits for the rising level. Finally, it holds edge-triggered and disabled interrupt pins low and checks that none of them restarts the oscillator.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_RESET = 3'd0,
        MODE_RUN   = 3'd1,
        MODE_IDLE  = 3'd2,
        MODE_PD    = 3'd3,
        MODE_WAKE  = 3'd4,
        MODE_EMU   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        DRV_FUNC = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_LOW  = 2'd2,
        DRV_WEAK = 2'd3
    } drv_e;

    typedef enum logic [1:0] {
        P0_FUNC  = 2'd0,
        P0_HOLD  = 2'd1,
        P0_FLOAT = 2'd2
    } p0_e;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sy_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_o = sy_q.s2;

endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int HOLD_CYC = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_s_i,
    output logic rst_ok_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!pin_s_i) begin
            cnt_d = '0;
        end else if (cnt_q == LIMIT) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign rst_ok_o = (cnt_q == LIMIT);

    // R1
    rst_ok_needs_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ok_o) |-> $past(pin_s_i));

    // R1
    rst_ok_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_ok_o) |-> !$past(pin_s_i));

endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
    parameter int NUM_INT = 2
) (
    input  logic [NUM_INT-1:0] lvl_n_i,
    input  logic [NUM_INT-1:0] en_i,
    input  logic [NUM_INT-1:0] edge_i,
    output logic               wake_o
);

    logic [NUM_INT-1:0] hit;

    for (genvar gi = 0; gi < NUM_INT; gi++) begin : g_ch
        assign hit[gi] = en_i[gi] & ~edge_i[gi] & ~lvl_n_i[gi];
    end

    assign wake_o = |hit;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int MC_CYCLES = 12,
    parameter int RST_MC    = 2,
    parameter int NUM_INT   = 2,
    parameter int STAB_W    = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rst_pin_i,
    input  logic               ale_pin_i,
    input  logic               psen_pin_i,
    input  logic               idle_req_i,
    input  logic               pd_req_i,
    input  logic               irq_pend_i,
    input  logic [NUM_INT-1:0] ext_int_n_i,
    input  logic [NUM_INT-1:0] ext_int_en_i,
    input  logic [NUM_INT-1:0] ext_int_edge_i,
    input  logic               ext_exec_i,
    input  logic               cnt_idle_run_i,
    input  logic [STAB_W-1:0]  stab_cnt_i,
    output logic               core_rst_o,
    output logic               cpu_clk_en_o,
    output logic               osc_en_o,
    output logic               per_clk_en_o,
    output logic               cnt_clk_en_o,
    output logic [1:0]         ale_ctl_o,
    output logic [1:0]         psen_ctl_o,
    output logic [1:0]         p0_ctl_o,
    output logic               port_weak_o,
    output logic [2:0]         mode_o
);

    localparam int RST_CYC = MC_CYCLES * RST_MC;
    localparam int SYNC_W  = 3 + NUM_INT;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{NUM_INT{1'b1}}, 3'b110};

    logic [SYNC_W-1:0]  pins_s;
    logic               rst_s, ale_s, psen_s;
    logic [NUM_INT-1:0] int_s;
    logic               rst_ok;
    logic               wake;

    pmc_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({ext_int_n_i, psen_pin_i, ale_pin_i, rst_pin_i}),
        .sync_o  (pins_s)
    );

    assign rst_s  = pins_s[0];
    assign ale_s  = pins_s[1];
    assign psen_s = pins_s[2];
    assign int_s  = pins_s[SYNC_W-1:3];

    pmc_rst_qual #(
        .HOLD_CYC (RST_CYC)
    ) u_rst_qual (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pin_s_i  (rst_s),
        .rst_ok_o (rst_ok)
    );

    pmc_wake_qual #(
        .NUM_INT (NUM_INT)
    ) u_wake (
        .lvl_n_i (int_s),
        .en_i    (ext_int_en_i),
        .edge_i  (ext_int_edge_i),
        .wake_o  (wake)
    );

    typedef struct packed {
        mode_e             st;
        logic              arm;
        logic [STAB_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic stab_done;

    assign stab_done = (fsm_q.cnt == stab_cnt_i);

    always_comb begin
        fsm_d = fsm_q;
        if (rst_ok && fsm_q.st != MODE_RESET) begin
            fsm_d.st  = MODE_RESET;
            fsm_d.arm = 1'b0;
            fsm_d.cnt = '0;
        end else begin
            unique case (fsm_q.st)
                MODE_RESET: begin
                    if (!ale_s && psen_s) begin
                        fsm_d.arm = 1'b1;
                    end
                    if (!rst_ok) begin
                        fsm_d.st  = ((fsm_q.arm || (!ale_s && psen_s)) && !ale_s)
                                    ? MODE_EMU : MODE_RUN;
                        fsm_d.arm = 1'b0;
                    end
                end
                MODE_RUN: begin
                    if (pd_req_i) begin
                        fsm_d.st = MODE_PD;
                    end else if (idle_req_i) begin
                        fsm_d.st = MODE_IDLE;
                    end
                end
                MODE_IDLE: begin
                    if (irq_pend_i) begin
                        fsm_d.st = MODE_RUN;
                    end
                end
                MODE_PD: begin
                    fsm_d.cnt = '0;
                    if (wake) begin
                        fsm_d.st = MODE_WAKE;
                    end
                end
                MODE_WAKE: begin
                    if (!stab_done) begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end else if (!wake) begin
                        fsm_d.st  = MODE_RUN;
                        fsm_d.cnt = '0;
                    end
                end
                MODE_EMU: begin
                    fsm_d.st = MODE_EMU;
                end
                default: begin
                    fsm_d.st = MODE_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{st: MODE_RESET, arm: 1'b0, cnt: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    drv_e pin_drv;
    p0_e  p0_drv;

    always_comb begin
        core_rst_o   = 1'b0;
        cpu_clk_en_o = 1'b0;
        osc_en_o     = 1'b1;
        per_clk_en_o = 1'b0;
        cnt_clk_en_o = 1'b0;
        port_weak_o  = 1'b0;
        pin_drv      = DRV_FUNC;
        p0_drv       = P0_FUNC;
        unique case (fsm_q.st)
            MODE_RESET: begin
                core_rst_o = 1'b1;
                pin_drv    = DRV_WEAK;
                p0_drv     = P0_FLOAT;
            end
            MODE_RUN: begin
                cpu_clk_en_o = 1'b1;
                per_clk_en_o = 1'b1;
                cnt_clk_en_o = 1'b1;
            end
            MODE_IDLE: begin
                per_clk_en_o = 1'b1;
                cnt_clk_en_o = cnt_idle_run_i;
                pin_drv      = DRV_HIGH;
                p0_drv       = ext_exec_i ? P0_FLOAT : P0_HOLD;
            end
            MODE_PD: begin
                osc_en_o = rst_s | wake;
                pin_drv  = DRV_LOW;
                p0_drv   = ext_exec_i ? P0_FLOAT : P0_HOLD;
            end
            MODE_WAKE: begin
                pin_drv = DRV_LOW;
                p0_drv  = ext_exec_i ? P0_FLOAT : P0_HOLD;
            end
            MODE_EMU: begin
                port_weak_o = 1'b1;
                pin_drv     = DRV_WEAK;
                p0_drv      = P0_FLOAT;
            end
            default: begin
                core_rst_o = 1'b1;
            end
        endcase
    end

    assign ale_ctl_o  = pin_drv;
    assign psen_ctl_o = pin_drv;
    assign p0_ctl_o   = p0_drv;
    assign mode_o     = fsm_q.st;

    // R3
    emu_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(fsm_q.st) == MODE_RESET && fsm_q.st == MODE_EMU) |-> $past(!ale_s));

    // R4
    emu_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == MODE_EMU) |=> (fsm_q.st == MODE_EMU || fsm_q.st == MODE_RESET));

    // R6
    idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(fsm_q.st) == MODE_IDLE && fsm_q.st == MODE_RUN) |-> $past(irq_pend_i));

    // R10
    wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(fsm_q.st) == MODE_WAKE && fsm_q.st == MODE_RUN)
            |-> ($past(stab_done) && !$past(wake)));

    // R7
    clk_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_clk_en_o |-> (osc_en_o && per_clk_en_o));

    // R9
    pd_wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(fsm_q.st) == MODE_PD && fsm_q.st == MODE_WAKE) |-> $past(wake));

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

    localparam int MC      = 12;
    localparam int RMC     = 2;
    localparam int HOLD    = MC * RMC;
    localparam int NI      = 2;
    localparam int SW      = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_pin = 1'b0;
    logic          ale_pin = 1'b1;
    logic          psen_pin = 1'b1;
    logic          idle_req = 1'b0;
    logic          pd_req = 1'b0;
    logic          irq_pend = 1'b0;
    logic [NI-1:0] int_n = '1;
    logic [NI-1:0] int_en = '0;
    logic [NI-1:0] int_edge = '0;
    logic          ext_exec = 1'b0;
    logic          cnt_run = 1'b0;
    logic [SW-1:0] stab = 16'd10;

    logic          core_rst, cpu_en, osc_en, per_en, cnt_en, port_weak;
    logic [1:0]    ale_ctl, psen_ctl, p0_ctl;
    logic [2:0]    mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(
        .MC_CYCLES (MC),
        .RST_MC    (RMC),
        .NUM_INT   (NI),
        .STAB_W    (SW)
    ) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .rst_pin_i      (rst_pin),
        .ale_pin_i      (ale_pin),
        .psen_pin_i     (psen_pin),
        .idle_req_i     (idle_req),
        .pd_req_i       (pd_req),
        .irq_pend_i     (irq_pend),
        .ext_int_n_i    (int_n),
        .ext_int_en_i   (int_en),
        .ext_int_edge_i (int_edge),
        .ext_exec_i     (ext_exec),
        .cnt_idle_run_i (cnt_run),
        .stab_cnt_i     (stab),
        .core_rst_o     (core_rst),
        .cpu_clk_en_o   (cpu_en),
        .osc_en_o       (osc_en),
        .per_clk_en_o   (per_en),
        .cnt_clk_en_o   (cnt_en),
        .ale_ctl_o      (ale_ctl),
        .psen_ctl_o     (psen_ctl),
        .p0_ctl_o       (p0_ctl),
        .port_weak_o    (port_weak),
        .mode_o         (mode)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_idle();
        idle_req = 1'b1; wait_cyc(1); idle_req = 1'b0;
    endtask

    task automatic pulse_pd();
        pd_req = 1'b1; wait_cyc(1); pd_req = 1'b0;
    endtask

    task automatic full_reset();
        rst_pin = 1'b1; wait_cyc(HOLD + 6);
    endtask

    task automatic release_reset();
        rst_pin = 1'b0; wait_cyc(8);
    endtask

    task automatic t_power_on();
        chk("R1 reset state core_rst", core_rst, 1);
        chk("R1 reset state mode", mode, 0);
        rst_n = 1'b1;
        wait_cyc(6);
        chk("R2 power-on release mode", mode, 1);
        chk("R2 power-on release core_rst", core_rst, 0);
        chk("R8 run p0", p0_ctl, 0);
    endtask

    task automatic t_rst_qual();
        // R1: one cycle short of the qualifying hold
        rst_pin = 1'b1; wait_cyc(HOLD - 1); rst_pin = 1'b0;
        wait_cyc(6);
        chk("R1 short pulse mode", mode, 1);
        chk("R1 short pulse core_rst", core_rst, 0);
        full_reset();
        chk("R1 long pulse core_rst", core_rst, 1);
        chk("R1 long pulse mode", mode, 0);
        release_reset();
        chk("R2 release mode", mode, 1);
        chk("R2 release cpu clk", cpu_en, 1);
    endtask

    task automatic t_emu();
        full_reset();
        ale_pin = 1'b0; psen_pin = 1'b1; wait_cyc(3);
        release_reset();
        chk("R3 emu mode", mode, 5);
        chk("R3 emu p0 float", p0_ctl, 2);
        chk("R3 emu ale weak", ale_ctl, 3);
        chk("R3 emu psen weak", psen_ctl, 3);
        chk("R3 emu port weak", port_weak, 1);
        chk("R3 emu osc", osc_en, 1);
        chk("R3 emu cpu off", cpu_en, 0);
        pulse_idle(); wait_cyc(2);
        chk("R4 emu ignores idle", mode, 5);
        pulse_pd(); wait_cyc(2);
        chk("R4 emu ignores pd", mode, 5);
        irq_pend = 1'b1; wait_cyc(2); irq_pend = 1'b0;
        chk("R4 emu ignores irq", mode, 5);
        ale_pin = 1'b1;
        full_reset();
        chk("R4 emu left by reset", mode, 0);
        release_reset();
        chk("R4 run after emu", mode, 1);
        // R3: ALE low during reset but high again at release
        full_reset();
        ale_pin = 1'b0; wait_cyc(5); ale_pin = 1'b1; wait_cyc(5);
        release_reset();
        chk("R3 ale high at release gives run", mode, 1);
        // R3: PSEN low while ALE low
        full_reset();
        ale_pin = 1'b0; psen_pin = 1'b0; wait_cyc(5);
        release_reset();
        chk("R3 psen low gives run", mode, 1);
        ale_pin = 1'b1; psen_pin = 1'b1;
        wait_cyc(3);
    endtask

    task automatic t_idle();
        ext_exec = 1'b0; cnt_run = 1'b0;
        pulse_idle();
        chk("R5 idle mode", mode, 2);
        chk("R5 idle cpu off", cpu_en, 0);
        chk("R5 idle per on", per_en, 1);
        chk("R5 idle osc on", osc_en, 1);
        chk("R5 idle counter paused", cnt_en, 0);
        chk("R5 idle ale high", ale_ctl, 1);
        chk("R5 idle psen high", psen_ctl, 1);
        chk("R8 idle internal p0 hold", p0_ctl, 1);
        cnt_run = 1'b1; wait_cyc(1);
        chk("R5 idle counter runs", cnt_en, 1);
        ext_exec = 1'b1; wait_cyc(1);
        chk("R8 idle external p0 float", p0_ctl, 2);
        irq_pend = 1'b1; wait_cyc(1); irq_pend = 1'b0;
        chk("R6 idle exit mode", mode, 1);
        chk("R6 idle exit cpu", cpu_en, 1);
        ext_exec = 1'b0; cnt_run = 1'b0;
    endtask

    task automatic t_pd();
        pd_req = 1'b1; idle_req = 1'b1; wait_cyc(1);
        pd_req = 1'b0; idle_req = 1'b0;
        chk("R7 pd priority mode", mode, 3);
        chk("R7 pd osc off", osc_en, 0);
        chk("R7 pd per off", per_en, 0);
        chk("R7 pd ale low", ale_ctl, 2);
        chk("R8 pd internal p0 hold", p0_ctl, 1);
        irq_pend = 1'b1; wait_cyc(2); irq_pend = 1'b0;
        chk("R9 pd ignores irq flag", mode, 3);
        // R9: pin 1 edge-triggered, pin 0 disabled
        int_en = 2'b10; int_edge = 2'b10; int_n = 2'b00; wait_cyc(10);
        chk("R9 no wake osc", osc_en, 0);
        chk("R9 no wake mode", mode, 3);
        int_n = 2'b11; wait_cyc(3);
        // R10: short low, released before settling ends
        int_en = 2'b01; int_edge = 2'b00; stab = 16'd10;
        int_n = 2'b10; wait_cyc(3); int_n = 2'b11; wait_cyc(4);
        chk("R10 wake mode", mode, 4);
        chk("R10 wake osc", osc_en, 1);
        chk("R10 wake cpu off", cpu_en, 0);
        wait_cyc(20);
        chk("R10 exit after settle", mode, 1);
        chk("R10 exit cpu on", cpu_en, 1);
        // R10: held low beyond the settling count
        pulse_pd();
        int_n = 2'b10; wait_cyc(40);
        chk("R10 held low stays waking", mode, 4);
        int_n = 2'b11; wait_cyc(5);
        chk("R10 rising completes exit", mode, 1);
        int_en = 2'b00;
    endtask

    task automatic t_reset_exit();
        pulse_pd();
        full_reset();
        chk("R11 pd reset mode", mode, 0);
        release_reset();
        chk("R11 pd reset then run", mode, 1);
        pulse_idle();
        full_reset();
        chk("R11 idle reset mode", mode, 0);
        release_reset();
        chk("R11 idle reset then run", mode, 1);
        chk("R11 no weak ports", port_weak, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        wait_cyc(3);
        t_power_on();
        t_rst_qual();
        t_emu();
        t_idle();
        t_pd();
        t_reset_exit();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule